// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block is the receive side of an Ethernet DMA. Frames arrive from the MAC as a byte stream with a valid/ready pair, an end-of-frame marker and an error flag. The engine stores them in buffers that software has set up in a word-addressed memory. Each buffer is described by a four-word descriptor, and the descriptors form a ring.

The engine reads a descriptor and checks that it owns the descriptor. It then packs incoming bytes into little-endian words in that descriptor's buffer. When the frame or the buffer ends, it writes the status word back, which hands the descriptor to software, and moves on to the next descriptor. A frame longer than one buffer continues into the following descriptor.

If the engine meets a descriptor it does not own, it raises a no-descriptor flag and suspends. While suspended it drops any bytes that arrive. It resumes when software issues a poll demand, and it then reads the same descriptor again. A second flag reports each completed frame. Both flags are cleared by writing one to them.

Descriptor layout, one word per line:
- word 0 is status. The engine needs bit 31, the ownership bit, to be 1 before it uses the descriptor.
- word 1 holds the buffer size in bytes in bits 12:0 and the chain flag in bit 14.
- word 2 is the buffer word address.
- word 3 is the next-descriptor word address.

Top module: `rxd_ring_engine`

## Requirements
- R1: A `start` pulse in idle loads `ring_base` as the current descriptor. Every descriptor fetch then reads the four words at current+0..current+3.
- R2: If fetched word 0 has bit 31 clear, the engine sets `rx_status` bit 7 and suspends. While suspended, `rx_ready` is 1, the engine accepts and discards bytes, and it makes no memory write.
- R3: A suspended engine stays suspended and reads nothing until `poll_wr` is pulsed. It then reads the same descriptor again.
- R4: Bytes are packed little-endian: the first byte of each group of four goes to bits 7:0. Words are written at consecutive addresses starting at the word-2 address. The final partial word of a buffer is zero-padded.
- R5: Word 0 is written back with bit 31 clear. Bit 9 is set only on the first descriptor of a frame. On the last descriptor, bit 8 is set, bits 29:16 hold the total frame length in bytes, and bit 15 is set if `rx_err` was seen on any byte of the frame. These fields are zero on other descriptors.
- R6: When a frame reaches the buffer size in word 1 bits 12:0, the rest of the frame continues into the next owned descriptor.
- R7: The next descriptor is the word-3 address when word 1 bit 14 is set. Otherwise it is current+4.
- R8: `rx_status` bit 6 is set when a frame's last descriptor is written back. Writing `clr_data` with `clr_wr` clears exactly the status bits given as 1, and a set in the same cycle wins.
- R9: `rx_ready` is 0 in idle, during descriptor fetch and during write-back.
- R10: A frame that was in progress when the engine suspended, or that began while it was suspended, is dropped up to its last byte, even after a resume. The next frame starts with bit 9 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin operation at `ring_base` (used in idle only) |
| ring_base | input | AW | Word address of the first descriptor |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Byte is the last of its frame |
| rx_err | input | 1 | Frame error marker |
| rx_ready | output | 1 | Engine accepts a byte this cycle |
| poll_wr | input | 1 | Poll demand: resume a suspended engine |
| clr_wr | input | 1 | Write-one-to-clear strobe for the status flags |
| clr_data | input | 8 | Bits to clear (bit 6 frame done, bit 7 no descriptor) |
| rx_status | output | 8 | Status flags; bit 6 frame done, bit 7 no descriptor, others 0 |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |

## Verification
A descriptor read costs four request cycles plus one cycle of response latency, then one cycle to decide on ownership. `rx_ready` is therefore a registered function of state, and the bench offers a byte at a falling edge only after seeing ready there. After the byte that closes a buffer, the data word lands at the next edge and the status word one edge later. The status word and the frame-done flag change at the same edge. The bench therefore inspects descriptors and buffers only once it sees bit 6 of `rx_status` at a falling edge. Checks on suspension and on the following fetch address wait a fixed ten cycles, which covers the five-cycle fetch and the ownership decision.

// File: rtl/rxd_pkg.sv
// Shared definitions for the receive descriptor ring engine: engine states
// and the bit positions of descriptor and status fields that software decodes.
package rxd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CHECK,
        ST_RECV,
        ST_WB,
        ST_SUSP
    } rxd_state_e;

    localparam int DESC_WORDS = 4;
    localparam int OWN_BIT    = 31;
    localparam int ES_BIT     = 15;
    localparam int CHAIN_BIT  = 14;
    localparam int FS_BIT     = 9;
    localparam int LS_BIT     = 8;
    localparam int LEN_LSB    = 16;
    localparam int LEN_W      = 14;
    localparam int SIZE_W     = 13;
    localparam int STS_W      = 8;
    localparam int RI_BIT     = 6;
    localparam int RU_BIT     = 7;

endpackage

// File: rtl/rxd_packer.sv
// Byte-to-word assembler for one receive buffer.
// Assumes: start_buf pulses before the first byte of each buffer; a word is
// emitted on lane 3 or when close marks the buffer's final byte, and the
// emitted word is written by the parent in the very next cycle.
module rxd_packer
    import rxd_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_buf,
    input  logic              take,
    input  logic [7:0]        byte_in,
    input  logic              close,
    input  logic [AW-1:0]     buf_base,
    output logic              wr_pend,
    output logic [AW-1:0]     wr_addr,
    output logic [31:0]       wr_data,
    output logic [SIZE_W-1:0] fill
);

    logic [31:0] acc;
    logic [31:0] merged;

    // Place the incoming byte into its little-endian lane.
    always_comb begin
        merged = acc | ({24'b0, byte_in} << {fill[1:0], 3'b000});
    end

    // Accumulate bytes and hand full or closing words to the memory port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc     <= '0;
            fill    <= '0;
            wr_pend <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_pend <= 1'b0;
            if (start_buf) begin
                acc  <= '0;
                fill <= '0;
            end else if (take) begin
                fill <= fill + 1'b1;
                if (fill[1:0] == 2'b11 || close) begin
                    wr_pend <= 1'b1;
                    wr_data <= merged;
                    wr_addr <= buf_base + AW'(fill[SIZE_W-1:2]);
                    acc     <= '0;
                end else begin
                    acc <= merged;
                end
            end
        end
    end

    // R4
    wr_after_lane3_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !start_buf && fill[1:0] == 2'b11) |=> wr_pend);

endmodule

// File: rtl/rxd_status.sv
// Write-one-to-clear status flags of the receive engine.
// Assumes: set_vec pulses for one cycle per event; a set beats a clear of
// the same bit in the same cycle.
module rxd_status
    import rxd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [STS_W-1:0] set_vec,
    input  logic             clr_wr,
    input  logic [STS_W-1:0] clr_data,
    output logic [STS_W-1:0] sts_q
);

    logic [STS_W-1:0] clr_vec;

    // Only a strobed write clears flags.
    always_comb begin
        clr_vec = clr_wr ? clr_data : '0;
    end

    // Hold flags; clear requested bits, then merge new events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q <= '0;
        end else begin
            sts_q <= (sts_q & ~clr_vec) | set_vec;
        end
    end

    // R8
    ri_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_vec[RI_BIT] |=> sts_q[RI_BIT]);

    // R8
    ri_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && clr_data[RI_BIT] && !set_vec[RI_BIT]) |=> !sts_q[RI_BIT]);

    // R2
    ru_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_vec[RU_BIT] |=> sts_q[RU_BIT]);

endmodule

// File: rtl/rxd_ring_engine.sv
// Receive descriptor ring engine: fetches four-word descriptors, checks
// ownership, stores frame bytes into buffers, writes status back and follows
// the chain (or the next contiguous descriptor).
// Assumes: memory read data is valid one cycle after a read request and every
// request is granted at once; buffer sizes are nonzero.
module rxd_ring_engine
    import rxd_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [AW-1:0]    ring_base,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    input  logic             rx_last,
    input  logic             rx_err,
    output logic             rx_ready,
    input  logic             poll_wr,
    input  logic             clr_wr,
    input  logic [STS_W-1:0] clr_data,
    output logic [STS_W-1:0] rx_status,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic [31:0]      mem_rdata
);

    localparam int FC_W = $clog2(DESC_WORDS) + 1;
    localparam int IX_W = $clog2(DESC_WORDS);
    localparam int SZ1  = SIZE_W + 1;

    rxd_state_e        state;
    logic [AW-1:0]     cur;
    logic [31:0]       desc [DESC_WORDS];
    logic [FC_W-1:0]   fcnt;
    logic              rd_v;
    logic [IX_W-1:0]   rd_idx;
    logic              first;
    logic              wb_last;
    logic              err_acc;
    logic [LEN_W-1:0]  flen;
    logic              drop;

    logic              fetch_go;
    logic              wb_go;
    logic              take;
    logic              close;
    logic              start_buf;
    logic [SIZE_W-1:0] buf_size;
    logic [AW-1:0]     buf_base;
    logic [AW-1:0]     next_ptr;
    logic [31:0]       wb_word;
    logic [STS_W-1:0]  set_vec;
    logic [SZ1-1:0]    fill_nx;
    logic              pk_pend;
    logic [AW-1:0]     pk_addr;
    logic [31:0]       pk_data;
    logic [SIZE_W-1:0] fill;
    logic              unused_desc;

    // Decode the current descriptor and the per-cycle control strobes.
    always_comb begin
        buf_size  = desc[1][SIZE_W-1:0];
        buf_base  = desc[2][AW-1:0];
        next_ptr  = desc[1][CHAIN_BIT] ? desc[3][AW-1:0] : cur + AW'(DESC_WORDS);
        rx_ready  = (state == ST_RECV) || (state == ST_SUSP);
        take      = (state == ST_RECV) && rx_valid && !drop;
        fill_nx   = {1'b0, fill} + SZ1'(1);
        close     = rx_last || (fill_nx >= {1'b0, buf_size});
        fetch_go  = (state == ST_FETCH) && (fcnt < FC_W'(DESC_WORDS)) && !pk_pend;
        wb_go     = (state == ST_WB) && !pk_pend;
        start_buf = (state == ST_CHECK) && desc[0][OWN_BIT];
    end

    // Build the status word handed back to software.
    always_comb begin
        wb_word                      = '0;
        wb_word[FS_BIT]              = first;
        wb_word[LS_BIT]              = wb_last;
        wb_word[ES_BIT]              = wb_last && err_acc;
        wb_word[LEN_LSB +: LEN_W]    = wb_last ? flen : '0;
    end

    // Status events raised by the engine.
    always_comb begin
        set_vec         = '0;
        set_vec[RI_BIT] = wb_go && wb_last;
        set_vec[RU_BIT] = (state == ST_CHECK) && !desc[0][OWN_BIT];
    end

    // Memory port: buffer data first, then fetch reads, then status write-back.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        if (pk_pend) begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = pk_addr;
            mem_wdata = pk_data;
        end else if (fetch_go) begin
            mem_req  = 1'b1;
            mem_addr = cur + AW'(fcnt);
        end else if (wb_go) begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = cur;
            mem_wdata = wb_word;
        end
    end

    // Capture fetched descriptor words one cycle after each read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_v   <= 1'b0;
            rd_idx <= '0;
            for (int i = 0; i < DESC_WORDS; i++) desc[i] <= '0;
        end else begin
            rd_v   <= fetch_go;
            rd_idx <= fcnt[IX_W-1:0];
            if (rd_v) desc[rd_idx] <= mem_rdata;
        end
    end

    // Engine sequencing: fetch, ownership decision, receive, write-back, suspend.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cur     <= '0;
            fcnt    <= '0;
            first   <= 1'b1;
            wb_last <= 1'b0;
            err_acc <= 1'b0;
            flen    <= '0;
            drop    <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        cur     <= ring_base;
                        fcnt    <= '0;
                        first   <= 1'b1;
                        flen    <= '0;
                        err_acc <= 1'b0;
                        drop    <= 1'b0;
                        state   <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (fetch_go) fcnt <= fcnt + 1'b1;
                    if (rd_v && rd_idx == IX_W'(DESC_WORDS - 1)) state <= ST_CHECK;
                end
                ST_CHECK: begin
                    if (desc[0][OWN_BIT]) begin
                        state <= ST_RECV;
                    end else begin
                        drop    <= drop || !first;
                        first   <= 1'b1;
                        flen    <= '0;
                        err_acc <= 1'b0;
                        state   <= ST_SUSP;
                    end
                end
                ST_RECV: begin
                    if (rx_valid && drop && rx_last) drop <= 1'b0;
                    if (take) begin
                        flen    <= flen + 1'b1;
                        err_acc <= err_acc || rx_err;
                        if (close) begin
                            wb_last <= rx_last;
                            state   <= ST_WB;
                        end
                    end
                end
                ST_WB: begin
                    if (wb_go) begin
                        cur   <= next_ptr;
                        fcnt  <= '0;
                        state <= ST_FETCH;
                        if (wb_last) begin
                            first   <= 1'b1;
                            flen    <= '0;
                            err_acc <= 1'b0;
                        end else begin
                            first <= 1'b0;
                        end
                    end
                end
                ST_SUSP: begin
                    if (rx_valid) drop <= !rx_last;
                    if (poll_wr) begin
                        fcnt  <= '0;
                        state <= ST_FETCH;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign unused_desc = ^{desc[0], desc[1], desc[2], desc[3]};

    rxd_packer #(.AW(AW)) u_packer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_buf (start_buf),
        .take      (take),
        .byte_in   (rx_data),
        .close     (close),
        .buf_base  (buf_base),
        .wr_pend   (pk_pend),
        .wr_addr   (pk_addr),
        .wr_data   (pk_data),
        .fill      (fill)
    );

    rxd_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .clr_wr   (clr_wr),
        .clr_data (clr_data),
        .sts_q    (rx_status)
    );

    // R1
    fetch_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> ((mem_addr - cur) < AW'(DESC_WORDS)));

    // R3
    susp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SUSP && !poll_wr) |=> (state == ST_SUSP));

    // R5
    own_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_go && mem_req && mem_we) |-> !mem_wdata[OWN_BIT]);

    // R6
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> ({1'b0, fill} < {1'b0, buf_size}));

endmodule

// File: tb/rxd_ring_engine_bench.sv
module rxd_ring_engine_bench;
    localparam int CLK_NS = 10;
    localparam int AW     = 16;
    localparam int WD_CYC = 150000;
    localparam int BSZ    = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [AW-1:0] ring_base = '0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_last = 1'b0;
    logic        rx_err = 1'b0;
    logic        rx_ready;
    logic        poll_wr = 1'b0;
    logic        clr_wr = 1'b0;
    logic [7:0]  clr_data = '0;
    logic [7:0]  rx_status;
    logic        mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;

    logic [31:0] mem [0:1023];
    logic        tb_we = 1'b0;
    logic [9:0]  tb_addr = '0;
    logic [31:0] tb_wdata = '0;
    int          rd_count = 0;
    int          wr_count = 0;
    int          last_fetch = 0;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    logic [7:0] fbuf [0:63];
    int unsigned ring_a [4] = '{32'h100, 32'h140, 32'h120, 32'h160};
    int unsigned buf_a  [4] = '{32'h200, 32'h210, 32'h220, 32'h230};
    int ptr = 0;

    always #(CLK_NS/2) clk = ~clk;

    rxd_ring_engine #(.AW(AW)) u_rxd_ring_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .ring_base(ring_base),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_err(rx_err),
        .rx_ready(rx_ready), .poll_wr(poll_wr), .clr_wr(clr_wr), .clr_data(clr_data),
        .rx_status(rx_status), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Memory model with one cycle of read latency; the engine wins over bench writes.
    always_ff @(posedge clk) begin
        if (mem_req && mem_we) begin
            mem[mem_addr[9:0]] <= mem_wdata;
            wr_count <= wr_count + 1;
        end else if (tb_we) begin
            mem[tb_addr] <= tb_wdata;
        end
        if (mem_req && !mem_we) begin
            mem_rdata <= mem[mem_addr[9:0]];
            rd_count  <= rd_count + 1;
            if (mem_addr[1:0] == 2'b00) last_fetch <= int'(mem_addr);
        end
    end

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_mem(input int unsigned a, input logic [31:0] d);
        @(negedge clk);
        tb_we = 1'b1; tb_addr = a[9:0]; tb_wdata = d;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic set_desc(input int unsigned a, input bit own, input bit chain,
                            input int unsigned bufp, input int unsigned nxt);
        wr_mem(a,     own ? 32'h8000_0000 : 32'h0);
        wr_mem(a + 1, (chain ? 32'h4000 : 32'h0) | BSZ);
        wr_mem(a + 2, bufp);
        wr_mem(a + 3, nxt);
    endtask

    task automatic pulse_start(input int unsigned base);
        @(negedge clk);
        start = 1'b1; ring_base = base[AW-1:0];
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic clear_sts(input logic [7:0] m);
        @(negedge clk);
        clr_wr = 1'b1; clr_data = m;
        @(negedge clk);
        clr_wr = 1'b0; clr_data = '0;
    endtask

    // Called at a falling edge; returns at the falling edge after acceptance.
    task automatic send_byte(input logic [7:0] b, input logic l, input logic e);
        rx_valid = 1'b1; rx_data = b; rx_last = l; rx_err = e;
        while (!rx_ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic send_frame(input int len, input bit err);
        for (int i = 0; i < len; i++) fbuf[i] = 8'($urandom);
        @(negedge clk);
        for (int i = 0; i < len; i++) send_byte(fbuf[i], i == len - 1, err && (i == len - 1));
        rx_valid = 1'b0; rx_last = 1'b0; rx_err = 1'b0;
    endtask

    task automatic wait_ri();
        for (int t = 0; t < 3000 && !rx_status[6]; t++) @(negedge clk);
    endtask

    function automatic logic [31:0] exp_status(input bit fs, input bit ls, input bit es, input int len);
        logic [31:0] w = '0;
        w[9] = fs;
        w[8] = ls;
        if (ls) begin
            w[15]    = es;
            w[29:16] = 14'(len);
        end
        return w;
    endfunction

    function automatic logic [31:0] exp_word(input int base_idx, input int len);
        logic [31:0] w = '0;
        for (int k = 0; k < 4; k++)
            if (base_idx + k < len) w[8*k +: 8] = fbuf[base_idx + k];
        return w;
    endfunction

    // Compare the descriptors and buffers a frame used, then hand them back to the engine.
    task automatic check_frame(input int len, input bit err, input int unsigned ra [4], input int unsigned ba [4]);
        int nd = (len + BSZ - 1) / BSZ;
        for (int d = 0; d < nd; d++) begin
            int idx = (ptr + d) % 4;
            int chunk = (len - d * BSZ > BSZ) ? BSZ : len - d * BSZ;
            check_eq(d == 0 ? "R5 status" : "R6 continued status", mem[ra[idx][9:0]],
                     exp_status(d == 0, d == nd - 1, err, len));
            for (int w = 0; w < (chunk + 3) / 4; w++)
                check_eq("R4 buffer word", mem[ba[idx][9:0] + 10'(w)], exp_word(d * BSZ + w * 4, len));
        end
        for (int d = 0; d < nd; d++) wr_mem(ra[(ptr + d) % 4], 32'h8000_0000);
        ptr = (ptr + nd) % 4;
        clear_sts(8'h40);
    endtask

    initial begin
        repeat (WD_CYC) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
            $finish;
        end
    end

    initial begin
        int c0;
        int len;
        bit err;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // Reset state: R9 idle not ready, R8 flags clear
        check_eq("R9 reset ready", {31'b0, rx_ready}, 32'h0);
        check_eq("R8 reset status", {24'b0, rx_status}, 32'h0);
        check_eq("R1 reset no access", {31'b0, mem_req}, 32'h0);
        rst_n = 1'b1;

        // Ring with non-contiguous chaining; first descriptor not yet owned.
        for (int i = 0; i < 4; i++)
            set_desc(ring_a[i], i != 0, 1'b1, buf_a[i], ring_a[(i + 1) % 4]);
        @(negedge clk);
        check_eq("R9 idle ready", {31'b0, rx_ready}, 32'h0);
        pulse_start(ring_a[0]);
        repeat (10) @(negedge clk);
        check_eq("R2 no-descriptor flag", {31'b0, rx_status[7]}, 32'h1);
        check_eq("R1 first fetch address", last_fetch, ring_a[0]);
        check_eq("R2 ready while suspended", {31'b0, rx_ready}, 32'h1);
        c0 = wr_count;
        for (int i = 0; i < 3; i++) send_byte(8'hA0 + 8'(i), 1'b0, 1'b0);
        rx_valid = 1'b0;
        repeat (3) @(negedge clk);
        check_eq("R2 no writes while suspended", wr_count, c0);

        wr_mem(ring_a[0], 32'h8000_0000);
        clear_sts(8'h80);
        check_eq("R8 clear no-descriptor", {24'b0, rx_status}, 32'h0);
        c0 = rd_count;
        repeat (6) @(negedge clk);
        check_eq("R3 no fetch without poll", rd_count, c0);
        poll_wr = 1'b1;
        @(negedge clk);
        poll_wr = 1'b0;
        check_eq("R9 not ready during fetch", {31'b0, rx_ready}, 32'h0);
        // Tail of the frame begun while suspended must be dropped (R10).
        send_byte(8'hB0, 1'b0, 1'b0);
        send_byte(8'hB1, 1'b1, 1'b0);
        rx_valid = 1'b0; rx_last = 1'b0;
        check_eq("R3 refetch same descriptor", last_fetch, ring_a[0]);
        send_frame(6, 1'b0);
        wait_ri();
        check_eq("R8 frame-done flag", {31'b0, rx_status[6]}, 32'h1);
        check_eq("R10 fresh frame after resume", mem[ring_a[0][9:0]], exp_status(1, 1, 0, 6));
        repeat (10) @(negedge clk);
        check_eq("R7 chained next address", last_fetch, ring_a[1]);
        clear_sts(8'h80);
        check_eq("R8 clear other bit keeps flag", {31'b0, rx_status[6]}, 32'h1);
        check_frame(6, 1'b0, ring_a, buf_a);
        check_eq("R8 clear frame-done", {24'b0, rx_status}, 32'h0);

        // Directed lengths at buffer boundaries, then random frames.
        for (int t = 0; t < 34; t++) begin
            case (t)
                0: begin len = 16; err = 0; end
                1: begin len = 17; err = 0; end
                2: begin len = 32; err = 1; end
                3: begin len = 1;  err = 1; end
                4: begin len = 48 - 8; err = 0; end
                default: begin len = 1 + int'($urandom % 40); err = ($urandom % 4) == 0; end
            endcase
            send_frame(len, err);
            wait_ri();
            check_eq("R8 frame-done per frame", {31'b0, rx_status[6]}, 32'h1);
            check_frame(len, err, ring_a, buf_a);
        end

        // Unchained descriptor: next one is the contiguous address.
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        set_desc(32'h180, 1'b1, 1'b0, 32'h240, 32'h3F0);
        wr_mem(32'h184, 32'h0);
        pulse_start(32'h180);
        send_frame(4, 1'b0);
        wait_ri();
        check_eq("R5 single descriptor status", mem[10'h180], exp_status(1, 1, 0, 4));
        check_eq("R4 single word", mem[10'h240], exp_word(0, 4));
        repeat (10) @(negedge clk);
        check_eq("R7 contiguous next address", last_fetch, 32'h184);
        check_eq("R2 suspended on unowned", {31'b0, rx_status[7]}, 32'h1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule